// File: doc/BRIEF.md
# Transport Stream Sync Locker

This block sits behind a demodulator's transport stream interface. It finds 188-byte (or any programmed length) packet boundaries in the incoming stream and hands the packets on as aligned bytes. The stream arrives as a level-sampled stream clock plus valid, start and data lines. It is captured on the rising or the falling edge of that clock. Mode `cfg_serial` chooses between one bit per edge, assembled most-significant bit first, and one whole byte per edge.

A lock tracker looks for the sync token 0x47. It treats every token found while unlocked as a possible packet start. A candidate is confirmed only when the token comes back exactly one packet length later. Lock is declared after a programmable run of good sync bytes. Once locked, the tracker keeps its packet count running across damaged headers. It drops lock after a separately programmable run of missing sync bytes.

Only packets that fall wholly inside the locked period reach the output. Each forwarded packet carries start and end markers. The `locked` flag reports the tracker's state.

Top module: `ts_sync_locker`

## Requirements
- R1: While `rst_n` is low and right after it is released, `locked` and `out_valid` are 0, and the byte assembler and all counters are cleared.
- R2: A symbol is taken when the synchronised `ts_clk` rises, or when it falls if `cfg_clk_inv` is 1. A symbol taken with `ts_valid` low carries no data and has no effect on lock or on the output.
- R3: With `cfg_serial`=0 each symbol is a whole byte on `ts_data[7:0]`. With `cfg_serial`=1 each symbol is one bit on `ts_data[0]`, and eight bits form a byte with the first-received bit as bit 7.
- R4: In serial mode, while hunting, the byte alignment snaps to any run of eight bits that equals 0x47. A bit that arrives with `ts_sop`=1 restarts byte assembly at any time, and that bit becomes bit 7 of the next byte.
- R5: While unlocked, a 0x47 byte opens a candidate. The candidate stands only if 0x47 appears again exactly `cfg_pkt_len` bytes later. Any other byte at that position abandons the candidate, and hunting resumes with the next byte.
- R6: Lock is gained at the `cfg_acq_cnt`-th consecutive 0x47 spaced `cfg_pkt_len` bytes apart, counting the first candidate. A value of 0 or 1 locks on the first token. `locked` rises in the cycle in which that sync byte leaves on the output.
- R7: While locked, each packet whose first byte is not 0x47 adds one to a miss count, and a good sync byte clears that count. When the count reaches `cfg_drop_cnt`, lock is dropped; a value of 0 acts as 1.
- R8: Forwarding starts with the sync byte that gains lock and covers whole packets only. Packets received before lock, and the packet whose header drops lock, are discarded. A packet with a bad header that does not yet drop lock is forwarded complete, header included.
- R9: Within each forwarded packet, `out_sop` marks byte 0 and `out_eop` marks byte `cfg_pkt_len`-1. Both are only ever 1 together with `out_valid`. `cfg_pkt_len` is at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the stream clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_serial | input | 1 | 1: one bit per symbol on ts_data[0]; 0: one byte per symbol |
| cfg_clk_inv | input | 1 | 1: take symbols on the falling stream clock edge |
| cfg_pkt_len | input | LEN_W | Packet length in bytes (nominal 188) |
| cfg_acq_cnt | input | CNT_W | Consecutive good sync bytes needed for lock (nominal 9) |
| cfg_drop_cnt | input | CNT_W | Consecutive missing sync bytes that drop lock (nominal 9) |
| ts_clk | input | 1 | Stream clock, level-sampled |
| ts_valid | input | 1 | Stream data valid |
| ts_sop | input | 1 | Optional start-of-packet strobe, used for serial byte alignment |
| ts_data | input | 8 | Stream data (serial bit on bit 0) |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded byte |
| out_sop | output | 1 | First byte of a forwarded packet |
| out_eop | output | 1 | Last byte of a forwarded packet |
| locked | output | 1 | Tracker is in the locked state |

## Verification
The bound checker watches a set of output framing rules on every cycle:
- markers never appear without valid data;
- nothing is forwarded while unlocked;
- lock rises only on an emitted 0x47 start byte, and falls on a cycle with no output;
- every forwarded packet runs from its start marker to its end marker at exactly the programmed length, and is never cut short.

Several behaviours can only be shown by the bench scenarios:
- which packets are kept or dropped;
- that acquire and drop counts are honoured, including the miss count clearing on a good header;
- that a false candidate delays lock by one packet;
- the edge polarity, and that symbols without valid are ignored;
- MSB-first serial assembly and realignment on the start strobe.

These are covered in parallel and serial mode, with both edge polarities and with the nominal 188-byte setting.

// File: rtl/tsl_pkg.sv
`timescale 1ns/1ps
package tsl_pkg;
  localparam logic [7:0] SYNC_TOKEN = 8'h47;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } lock_state_e;

  typedef struct packed {
    logic       lvl;
    logic       vld;
    logic       sop;
    logic [7:0] data;
  } ts_sample_t;
endpackage

// File: rtl/tsl_edge_sampler.sv
`timescale 1ns/1ps
module tsl_edge_sampler
  import tsl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_clk_inv,
  input  logic       ts_clk,
  input  logic       ts_valid,
  input  logic       ts_sop,
  input  logic [7:0] ts_data,
  output logic       smp_stb,
  output logic       smp_sop,
  output logic [7:0] smp_data
);
  localparam int SW = $bits(ts_sample_t);
  localparam int CW = SYNC_STAGES * SW;

  ts_sample_t       cur_sample;
  ts_sample_t       tail;
  logic [CW-1:0]    chain_q, chain_d;
  logic             prev_lvl_q;
  logic             edge_hit;
  logic             stb_d, sop_d;
  logic [7:0]       data_d;

  assign cur_sample = '{lvl: ts_clk, vld: ts_valid, sop: ts_sop, data: ts_data};

  // Synchroniser depth picks the shift structure.
  generate
    if (SYNC_STAGES == 1) begin : g_one_stage
      assign chain_d = cur_sample;
    end else begin : g_multi_stage
      assign chain_d = {chain_q[CW-SW-1:0], cur_sample};
    end
  endgenerate

  assign tail = ts_sample_t'(chain_q[CW-1 -: SW]);

  always_comb begin
    edge_hit = cfg_clk_inv ? (prev_lvl_q & ~tail.lvl) : (~prev_lvl_q & tail.lvl);
    stb_d    = edge_hit & tail.vld;
    sop_d    = edge_hit & tail.vld & tail.sop;
    data_d   = stb_d ? tail.data : smp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q    <= '0;
      prev_lvl_q <= 1'b0;
      smp_stb    <= 1'b0;
      smp_sop    <= 1'b0;
      smp_data   <= '0;
    end else begin
      chain_q    <= chain_d;
      prev_lvl_q <= tail.lvl;
      smp_stb    <= stb_d;
      smp_sop    <= sop_d;
      smp_data   <= data_d;
    end
  end
endmodule

// File: rtl/tsl_byte_assembler.sv
`timescale 1ns/1ps
module tsl_byte_assembler
  import tsl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_serial,
  input  logic       hunting,
  input  logic       smp_stb,
  input  logic       smp_sop,
  input  logic [7:0] smp_data,
  output logic       byte_stb,
  output logic [7:0] byte_data
);
  logic [7:0] shreg_q, shreg_d;
  logic [2:0] cnt_q, cnt_d;
  logic [7:0] window;
  logic [2:0] have;
  logic       full, token_hit, ser_emit;
  logic       ser_en;
  logic       stb_d;
  logic [7:0] byte_d;

  always_comb begin
    window    = {shreg_q[6:0], smp_data[0]};
    have      = smp_sop ? 3'd0 : cnt_q;
    full      = (have == 3'd7);
    token_hit = hunting & ~smp_sop & (window == SYNC_TOKEN);
    ser_emit  = full | token_hit;
    ser_en    = cfg_serial & smp_stb;
    shreg_d   = window;
    cnt_d     = ser_emit ? 3'd0 : have + 3'd1;
    if (cfg_serial) begin
      stb_d  = smp_stb & ser_emit;
      byte_d = (smp_stb & ser_emit) ? window : byte_data;
    end else begin
      stb_d  = smp_stb;
      byte_d = smp_stb ? smp_data : byte_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (ser_en) begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_stb  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_stb  <= stb_d;
      byte_data <= byte_d;
    end
  end
endmodule

// File: rtl/tsl_lock_tracker.sv
`timescale 1ns/1ps
module tsl_lock_tracker
  import tsl_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_pkt_len,
  input  logic [CNT_W-1:0] cfg_acq_cnt,
  input  logic [CNT_W-1:0] cfg_drop_cnt,
  input  logic             byte_stb,
  input  logic [7:0]       byte_data,
  output logic             hunting,
  output logic             locked,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop
);
  localparam int CW1 = CNT_W + 1;

  lock_state_e      st_q, st_d;
  logic [LEN_W-1:0] pos_q, pos_d, pos_last, pos_adv;
  logic [CNT_W-1:0] good_q, good_d, miss_q, miss_d;
  logic [CW1-1:0]   good_inc, miss_inc;
  logic             is_sync, at_head, at_tail;
  logic             acquire, lose, fwd;
  logic             vld_d, sop_d, eop_d;
  logic [7:0]       data_d;

  always_comb begin
    pos_last = cfg_pkt_len - LEN_W'(1);
    is_sync  = (byte_data == SYNC_TOKEN);
    at_head  = (pos_q == '0);
    at_tail  = (pos_q == pos_last);
    pos_adv  = at_tail ? '0 : pos_q + LEN_W'(1);
    good_inc = CW1'(good_q) + CW1'(1);
    miss_inc = CW1'(miss_q) + CW1'(1);
    st_d     = st_q;
    pos_d    = pos_q;
    good_d   = good_q;
    miss_d   = miss_q;
    acquire  = 1'b0;
    lose     = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (is_sync) begin
          pos_d = pos_adv;
          if (cfg_acq_cnt <= CNT_W'(1)) begin
            st_d    = ST_LOCKED;
            acquire = 1'b1;
            miss_d  = '0;
          end else begin
            st_d   = ST_VERIFY;
            good_d = CNT_W'(1);
          end
        end
      end
      ST_VERIFY: begin
        pos_d = pos_adv;
        if (at_head) begin
          if (!is_sync) begin
            st_d  = ST_HUNT;
            pos_d = '0;
          end else if (good_inc >= CW1'(cfg_acq_cnt)) begin
            st_d    = ST_LOCKED;
            acquire = 1'b1;
            miss_d  = '0;
          end else begin
            good_d = good_inc[CNT_W-1:0];
          end
        end
      end
      ST_LOCKED: begin
        pos_d = pos_adv;
        if (at_head) begin
          if (is_sync) begin
            miss_d = '0;
          end else if (miss_inc >= CW1'(cfg_drop_cnt)) begin
            st_d  = ST_HUNT;
            lose  = 1'b1;
            pos_d = '0;
          end else begin
            miss_d = miss_inc[CNT_W-1:0];
          end
        end
      end
      default: begin
        st_d  = ST_HUNT;
        pos_d = '0;
      end
    endcase
    fwd    = acquire | ((st_q == ST_LOCKED) & ~lose);
    vld_d  = byte_stb & fwd;
    sop_d  = byte_stb & fwd & at_head;
    eop_d  = byte_stb & fwd & at_tail;
    data_d = byte_stb ? byte_data : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      pos_q  <= '0;
      good_q <= '0;
      miss_q <= '0;
    end else if (byte_stb) begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      good_q <= good_d;
      miss_q <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      out_sop   <= sop_d;
      out_eop   <= eop_d;
      out_data  <= data_d;
    end
  end

  assign hunting = (st_q == ST_HUNT);
  assign locked  = (st_q == ST_LOCKED);
endmodule

// File: rtl/ts_sync_locker.sv
`timescale 1ns/1ps
module ts_sync_locker #(
  parameter int LEN_W       = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_serial,
  input  logic             cfg_clk_inv,
  input  logic [LEN_W-1:0] cfg_pkt_len,
  input  logic [CNT_W-1:0] cfg_acq_cnt,
  input  logic [CNT_W-1:0] cfg_drop_cnt,
  input  logic             ts_clk,
  input  logic             ts_valid,
  input  logic             ts_sop,
  input  logic [7:0]       ts_data,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             locked
);
  logic       smp_stb, smp_sop;
  logic [7:0] smp_data;
  logic       byte_stb;
  logic [7:0] byte_data;
  logic       hunting;

  tsl_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .cfg_clk_inv(cfg_clk_inv),
    .ts_clk(ts_clk), .ts_valid(ts_valid), .ts_sop(ts_sop), .ts_data(ts_data),
    .smp_stb(smp_stb), .smp_sop(smp_sop), .smp_data(smp_data)
  );

  tsl_byte_assembler u_assembler (
    .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .hunting(hunting),
    .smp_stb(smp_stb), .smp_sop(smp_sop), .smp_data(smp_data),
    .byte_stb(byte_stb), .byte_data(byte_data)
  );

  tsl_lock_tracker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_tracker (
    .clk(clk), .rst_n(rst_n),
    .cfg_pkt_len(cfg_pkt_len), .cfg_acq_cnt(cfg_acq_cnt), .cfg_drop_cnt(cfg_drop_cnt),
    .byte_stb(byte_stb), .byte_data(byte_data),
    .hunting(hunting), .locked(locked),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );
endmodule

// File: rtl/tsl_checker.sv
`timescale 1ns/1ps
module tsl_checker #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] cfg_pkt_len,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_sop,
  input logic             out_eop,
  input logic             locked
);
  logic [LEN_W-1:0] run_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else if (out_valid) begin
      run_q  <= out_sop ? LEN_W'(1) : run_q + LEN_W'(1);
      seen_q <= 1'b1;
    end
  end

  // R9
  marker_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop || out_eop) |-> out_valid);

  // R8
  fwd_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> locked);

  // R6
  lock_on_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (out_valid && out_sop && out_data == 8'h47));

  // R8
  lost_pkt_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !out_valid);

  // R9
  eop_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop && !out_sop) |-> (run_q == cfg_pkt_len - LEN_W'(1)));

  // R8
  whole_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop && seen_q) |-> (run_q == cfg_pkt_len));

  // R8
  first_is_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !seen_q) |-> out_sop);
endmodule

bind ts_sync_locker tsl_checker #(.LEN_W(LEN_W)) u_tsl_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pkt_len(cfg_pkt_len),
  .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
  .out_eop(out_eop), .locked(locked)
);

// File: tb/tb_ts_sync_locker.sv
`timescale 1ns/1ps
module tb_ts_sync_locker;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_serial, cfg_clk_inv;
  logic [7:0] cfg_pkt_len;
  logic [3:0] cfg_acq_cnt, cfg_drop_cnt;
  logic       ts_clk, ts_valid, ts_sop;
  logic [7:0] ts_data;
  logic       out_valid, out_sop, out_eop, locked;
  logic [7:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [9:0] expq[$];   // {sop, eop, data}
  logic [9:0] got, want;

  always #2.5 clk = ~clk;

  ts_sync_locker dut (
    .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .cfg_clk_inv(cfg_clk_inv),
    .cfg_pkt_len(cfg_pkt_len), .cfg_acq_cnt(cfg_acq_cnt), .cfg_drop_cnt(cfg_drop_cnt),
    .ts_clk(ts_clk), .ts_valid(ts_valid), .ts_sop(ts_sop), .ts_data(ts_data),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .locked(locked)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Every forwarded byte is compared with the next expected one (R8, R9).
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      got = {out_sop, out_eop, out_data};
      if (expq.size() == 0) begin
        chk(1'b0, "R8 byte forwarded that should be discarded", int'(got), 0);
      end else begin
        want = expq.pop_front();
        chk(got == want, "R8 R9 forwarded {sop,eop,data}", int'(got), int'(want));
      end
    end
  end

  // One symbol: the inactive edge sees complemented data, so a wrong polarity breaks lock (R2).
  task automatic sym(input logic [7:0] d, input logic v, input logic s);
    if (!cfg_clk_inv) begin
      ts_data = d;  ts_valid = v; ts_sop = s;    ts_clk = 1'b1;
    end else begin
      ts_data = ~d; ts_valid = v; ts_sop = 1'b0; ts_clk = 1'b1;
    end
    repeat (2) @(negedge clk);
    if (!cfg_clk_inv) begin
      ts_data = ~d; ts_sop = 1'b0; ts_clk = 1'b0;
    end else begin
      ts_data = d;  ts_sop = s;    ts_clk = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic s);
    if (!cfg_serial) sym(b, 1'b1, s);
    else for (int i = 7; i >= 0; i--) sym({7'd0, b[i]}, 1'b1, s && (i == 7));
  endtask

  task automatic send_pkt(input int idx, input logic [7:0] hdr, input bit fwd, input bit s);
    logic [7:0] b;
    for (int j = 0; j < int'(cfg_pkt_len); j++) begin
      b = (j == 0) ? hdr : 8'((idx + j) & 15);
      if (fwd) expq.push_back({(j == 0), (j == int'(cfg_pkt_len) - 1), b});
      send_byte(b, s && (j == 0));
    end
  endtask

  task automatic lock_is(input logic exp, input string tag);
    repeat (12) @(negedge clk);
    chk(locked == exp, tag, int'(locked), int'(exp));
  endtask

  task automatic drained(input string tag);
    repeat (16) @(negedge clk);
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask

  task automatic do_reset(input logic ser, input logic inv, input int len, input int acq, input int drp);
    rst_n = 1'b0;
    ts_clk = 1'b0; ts_valid = 1'b0; ts_sop = 1'b0; ts_data = 8'h00;
    cfg_serial = ser; cfg_clk_inv = inv;
    cfg_pkt_len = 8'(len); cfg_acq_cnt = 4'(acq); cfg_drop_cnt = 4'(drp);
    repeat (4) @(negedge clk);
    chk(locked == 1'b0 && out_valid == 1'b0, "R1 outputs held clear in reset",
        int'({locked, out_valid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(locked == 1'b0 && out_valid == 1'b0, "R1 outputs clear after reset",
        int'({locked, out_valid}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // Scenario A: parallel, rising edge, len 12, acquire 3, drop 2
    do_reset(1'b0, 1'b0, 12, 3, 2);
    for (int k = 0; k < 5; k++) send_byte(8'h11, 1'b0);
    send_pkt(0, 8'h47, 0, 0);
    send_pkt(1, 8'h47, 0, 0);
    lock_is(1'b0, "R6 not locked after two good syncs");
    send_pkt(2, 8'h47, 1, 0);
    lock_is(1'b1, "R6 locked at third good sync");
    send_pkt(3, 8'h47, 1, 0);
    sym(8'h47, 1'b0, 1'b0);   // R2: symbol without valid must be ignored
    send_pkt(4, 8'h47, 1, 0);
    send_pkt(5, 8'h47, 1, 0);
    lock_is(1'b1, "R2 invalid symbol left lock intact");
    send_pkt(6, 8'h00, 1, 0);
    lock_is(1'b1, "R7 one miss below drop count keeps lock");
    send_pkt(7, 8'h00, 0, 0);
    lock_is(1'b0, "R7 lock dropped at second miss");
    drained("R8 kept packets of first lock period all seen");
    send_pkt(8, 8'h47, 0, 0);
    send_pkt(9, 8'h47, 0, 0);
    send_pkt(10, 8'h47, 1, 0);
    send_pkt(11, 8'h47, 1, 0);
    lock_is(1'b1, "R5 relock after loss");
    drained("R8 relocked packets all seen");

    // Scenario B: parallel, falling edge, len 8, acquire 3, drop 1, false candidate
    do_reset(1'b0, 1'b1, 8, 3, 1);
    send_byte(8'h47, 1'b0);
    for (int k = 0; k < 3; k++) send_byte(8'h11, 1'b0);
    send_pkt(0, 8'h47, 0, 0);
    send_pkt(1, 8'h47, 0, 0);
    send_pkt(2, 8'h47, 0, 0);
    lock_is(1'b0, "R5 false candidate delays lock by one packet");
    send_pkt(3, 8'h47, 1, 0);
    lock_is(1'b1, "R2 locked on falling edge capture");
    send_pkt(4, 8'h47, 1, 0);
    send_pkt(5, 8'h47, 1, 0);
    send_pkt(6, 8'h5A, 0, 0);
    lock_is(1'b0, "R7 drop count 1 loses lock on first miss");
    drained("R8 falling edge packets all seen");

    // Scenario C: serial MSB first, len 6, acquire 2, drop 3
    do_reset(1'b1, 1'b0, 6, 2, 3);
    for (int k = 0; k < 13; k++) sym(8'h01, 1'b1, 1'b0);
    send_pkt(0, 8'h47, 0, 0);
    send_pkt(1, 8'h47, 1, 0);
    lock_is(1'b1, "R3 R4 serial lock at second sync");
    send_pkt(2, 8'h47, 1, 0);
    send_pkt(3, 8'h47, 1, 0);
    send_pkt(4, 8'h00, 1, 0);
    send_pkt(5, 8'h00, 1, 0);
    send_pkt(6, 8'h47, 1, 0);
    send_pkt(7, 8'h00, 1, 0);
    send_pkt(8, 8'h00, 1, 0);
    send_pkt(9, 8'h47, 1, 0);
    lock_is(1'b1, "R7 good sync clears miss count");
    sym(8'h01, 1'b1, 1'b0);   // stray bit
    send_pkt(10, 8'h47, 1, 1);
    lock_is(1'b1, "R4 start strobe realigns serial bytes");
    send_pkt(11, 8'h00, 1, 0);
    send_pkt(12, 8'h00, 1, 0);
    send_pkt(13, 8'h00, 0, 0);
    lock_is(1'b0, "R7 serial lock lost at third miss");
    drained("R8 serial packets all seen");

    // Scenario D: nominal 188-byte packets, acquire 9, drop 9
    do_reset(1'b0, 1'b0, 188, 9, 9);
    for (int k = 0; k < 8; k++) send_pkt(k, 8'h47, 0, 0);
    lock_is(1'b0, "R6 nominal: no lock after eight syncs");
    send_pkt(8, 8'h47, 1, 0);
    send_pkt(9, 8'h47, 1, 0);
    lock_is(1'b1, "R6 nominal: lock at ninth sync");
    drained("R9 nominal packets framed");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule